// File: doc/BRIEF.md
# Micro-Page Access Counter Table

This block sits beside a memory controller's request path and counts how often each 1 KB region of physical memory (a micro-page) is touched during an epoch. Every accepted request strobe carries a 32-bit physical address. The block drops the low ten bits to get a 22-bit micro-page identifier. It hashes that identifier down to a slot index in a direct-mapped table. The slot then holds the identifier as a tag, with a saturating hit count and a valid flag.

Each 4 KB page spans four neighbouring micro-pages. The table has no associative search: a request whose identifier hashes onto a slot owned by another identifier takes the slot over. Counts are therefore approximate when the hot footprint crowds the table. The update path has no handshake and never holds back a request.

At an epoch boundary, software walks the slots through a registered readout port and ranks the hot regions itself. It then pulses an epoch-clear control. This control invalidates one slot per cycle until every slot has been swept, and the table ignores requests while the sweep runs.

Top module: `mpage_hit_table`

## Requirements
- R1: The tag stored for a request is physical address bits [31:10]. Two addresses that differ only in bits [9:0] update the same slot with the same tag.
- R2: The slot index is the XOR of tag bits [8:0], tag bits [17:9] and tag bits [21:18] zero-extended to 9 bits.
- R3: A request to an invalid slot, or to a valid slot holding a different tag, leaves that slot valid, holding the new tag, with a count of 1.
- R4: A request whose tag matches the valid slot's tag adds one to the slot's count.
- R5: A count that has reached 65535 stays at 65535 on further matching requests.
- R6: The table accepts a request on every cycle with no stall. Back-to-back requests on consecutive cycles are each counted.
- R7: A pulse on epoch_clear while idle raises clear_busy at the next edge. clear_busy then stays high for exactly 512 cycles, and afterwards every slot reads as invalid.
- R8: A request presented in the same cycle as an accepted epoch_clear, or while clear_busy is high, leaves the table unchanged.
- R9: The readout port returns the valid flag, tag and count of slot rd_idx at the clock edge after rd_idx is sampled. Its value reflects all updates made before that edge.
- R10: After reset every slot reads as invalid, clear_busy is low and the readout outputs are zero.
- R11: An epoch_clear pulse while clear_busy is high is ignored and does not lengthen the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe from the controller |
| req_addr | input | 32 | Physical address of the request |
| epoch_clear | input | 1 | Pulse that starts the invalidation sweep |
| clear_busy | output | 1 | High while the sweep runs |
| rd_idx | input | 9 | Slot index to read out |
| rd_valid | output | 1 | Valid flag of the slot read |
| rd_tag | output | 22 | Tag of the slot read |
| rd_count | output | 16 | Hit count of the slot read |

## Verification
The counting path is tried with four kinds of traffic. Repeated requests to one micro-page with different byte offsets show that the low address bits are ignored and that hits accumulate. A pair of identifiers built to share a hash slot shows that ownership is replaced and the count restarts, as opposed to merging into one count. Requests on consecutive cycles to distinct slots, and then a repeat, show that nothing is lost when there is no idle gap. A run of more than 65535 hits shows that the count saturates rather than wrapping. Requests issued during a sweep, together with a second clear pulse in mid-sweep, separate dropped traffic from accepted traffic and show the sweep length is fixed.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
   localparam int unsigned MPT_ADDR_W  = 32;
   localparam int unsigned MPT_SHIFT   = 10;
   localparam int unsigned MPT_SLOTS   = 512;
   localparam int unsigned MPT_CNT_W   = 16;

   typedef enum logic {
      SWEEP_IDLE = 1'b0,
      SWEEP_RUN  = 1'b1
   } sweep_state_e;
endpackage

// File: rtl/mpt_hash.sv
module mpt_hash #(
   parameter int unsigned TAG_W = 22,
   parameter int unsigned IDX_W = 9
) (
   input  logic [TAG_W-1:0] tag,
   output logic [IDX_W-1:0] idx
);
   initial begin
      assert (IDX_W >= 1 && TAG_W >= 1)
         else $error("mpt_hash: widths must be positive");
   end

   generate
      if (TAG_W <= IDX_W) begin : g_narrow
         always_comb idx = IDX_W'(tag);
      end else begin : g_fold
         // fold every IDX_W-wide chunk of the tag onto the index
         always_comb begin
            idx = '0;
            for (int b = 0; b < int'(TAG_W); b++) begin
               idx[b % int'(IDX_W)] = idx[b % int'(IDX_W)] ^ tag[b];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mpt_sweep.sv
module mpt_sweep #(
   parameter int unsigned SLOTS = 512,
   localparam int unsigned IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             clr_we,
   output logic [IDX_W-1:0] clr_idx
);
   import mpt_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   sweep_state_e     state_q;
   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SWEEP_IDLE;
         ptr_q   <= '0;
      end else begin
         case (state_q)
            SWEEP_IDLE: begin
               if (start) begin
                  state_q <= SWEEP_RUN;
                  ptr_q   <= '0;
               end
            end
            SWEEP_RUN: begin
               ptr_q <= ptr_q + IDX_W'(1);
               if (ptr_q == LAST) state_q <= SWEEP_IDLE;
            end
            default: state_q <= SWEEP_IDLE;
         endcase
      end
   end

   assign busy    = (state_q == SWEEP_RUN);
   assign clr_we  = busy;
   assign clr_idx = ptr_q;

   AST_SWEEP_STARTS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R7
   AST_SWEEP_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && clr_idx == LAST) |=> !busy); // R7
   AST_SWEEP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && clr_idx != LAST) |=> (busy && clr_idx == $past(clr_idx) + IDX_W'(1))); // R11
endmodule

// File: rtl/mpt_store.sv
module mpt_store #(
   parameter int unsigned SLOTS = 512,
   parameter int unsigned TAG_W = 22,
   parameter int unsigned CNT_W = 16,
   localparam int unsigned IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_we,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic             clr_we,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [CNT_W-1:0] rd_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             vld_q [SLOTS];
   logic [TAG_W-1:0] tag_q [SLOTS];
   logic [CNT_W-1:0] cnt_q [SLOTS];

   logic             same_tag;
   logic [CNT_W-1:0] next_cnt;

   always_comb begin
      same_tag = vld_q[upd_idx] && (tag_q[upd_idx] == upd_tag);
      if (!same_tag)                      next_cnt = CNT_W'(1);
      else if (cnt_q[upd_idx] == CNT_MAX) next_cnt = CNT_MAX;
      else                                next_cnt = cnt_q[upd_idx] + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(SLOTS); i++) vld_q[i] <= 1'b0;
      end else if (clr_we) begin
         vld_q[clr_idx] <= 1'b0;
      end else if (upd_we) begin
         vld_q[upd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_we && !clr_we) begin
         tag_q[upd_idx] <= upd_tag;
         cnt_q[upd_idx] <= next_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_tag   <= '0;
         rd_count <= '0;
      end else begin
         rd_valid <= vld_q[rd_idx];
         rd_tag   <= tag_q[rd_idx];
         rd_count <= cnt_q[rd_idx];
      end
   end

   AST_NO_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_we && clr_we)); // R8
   AST_UPDATE_OWNS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |=> (vld_q[$past(upd_idx)] && tag_q[$past(upd_idx)] == $past(upd_tag))); // R3
   AST_COUNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |=> (cnt_q[$past(upd_idx)] != '0)); // R5
   AST_SWEEP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> !vld_q[$past(clr_idx)]); // R7
endmodule

// File: rtl/mpage_hit_table.sv
module mpage_hit_table #(
   parameter int unsigned ADDR_W = mpt_pkg::MPT_ADDR_W,
   parameter int unsigned SHIFT  = mpt_pkg::MPT_SHIFT,
   parameter int unsigned SLOTS  = mpt_pkg::MPT_SLOTS,
   parameter int unsigned CNT_W  = mpt_pkg::MPT_CNT_W,
   localparam int unsigned TAG_W = ADDR_W - SHIFT,
   localparam int unsigned IDX_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              epoch_clear,
   output logic              clear_busy,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [CNT_W-1:0]  rd_count
);
   initial begin
      assert (SLOTS >= 2 && (1 << IDX_W) == SLOTS)
         else $error("mpage_hit_table: SLOTS must be a power of two");
      assert (ADDR_W > SHIFT)
         else $error("mpage_hit_table: SHIFT leaves no tag bits");
      assert (CNT_W >= 2)
         else $error("mpage_hit_table: counter too narrow");
   end

   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_slot;
   logic             accept;
   logic             sweep_we;
   logic [IDX_W-1:0] sweep_idx;
   logic             unused_offset;

   assign req_tag       = req_addr[ADDR_W-1:SHIFT];
   assign unused_offset = ^req_addr[SHIFT-1:0];

   mpt_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash (
      .tag (req_tag),
      .idx (req_slot)
   );

   mpt_sweep #(.SLOTS(SLOTS)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (epoch_clear),
      .busy    (clear_busy),
      .clr_we  (sweep_we),
      .clr_idx (sweep_idx)
   );

   assign accept = req_valid && !clear_busy && !epoch_clear;

   mpt_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_we   (accept),
      .upd_idx  (req_slot),
      .upd_tag  (req_tag),
      .clr_we   (sweep_we),
      .clr_idx  (sweep_idx),
      .rd_idx   (rd_idx),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_count (rd_count)
   );

   AST_BUSY_BLOCKS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && epoch_clear && !clear_busy) |=> clear_busy); // R8
endmodule

// File: tb/mpage_hit_table_tb.sv
`timescale 1ns/1ps
module mpage_hit_table_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        epoch_clear = 1'b0;
   logic        clear_busy;
   logic [8:0]  rd_idx = '0;
   logic        rd_valid;
   logic [21:0] rd_tag;
   logic [15:0] rd_count;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   mpage_hit_table u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .epoch_clear(epoch_clear), .clear_busy(clear_busy), .rd_idx(rd_idx),
      .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_count(rd_count)
   );

   function automatic logic [8:0] slot_of(input logic [21:0] t);
      return t[8:0] ^ t[17:9] ^ {5'b0, t[21:18]};
   endfunction

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_req(input logic [31:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic read_slot(input logic [8:0] s);
      @(negedge clk);
      rd_idx = s;
      @(negedge clk);
   endtask

   task automatic expect_slot(input string req, input logic [8:0] s,
                              input logic v, input logic [21:0] t, input int c);
      read_slot(s);
      chk(req, "valid", rd_valid, v);
      if (v) begin
         chk(req, "tag", rd_tag, t);
         chk(req, "count", rd_count, c);
      end
   endtask

   localparam logic [31:0] ADDR_A = 32'h1234_5678;
   localparam logic [21:0] TAG_A  = ADDR_A[31:10];
   localparam logic [21:0] TAG_B  = TAG_A ^ 22'h000201;

   task automatic t_reset;
      chk("R10", "busy", clear_busy, 0);
      chk("R10", "rd_count", rd_count, 0);
      chk("R10", "rd_tag", rd_tag, 0);
      expect_slot("R10", 9'd0, 1'b0, '0, 0);
      expect_slot("R10", slot_of(TAG_A), 1'b0, '0, 0);
   endtask

   task automatic t_first_and_repeat;
      do_req(ADDR_A);
      expect_slot("R3", slot_of(TAG_A), 1'b1, TAG_A, 1);
      do_req({TAG_A, 10'h000});
      do_req({TAG_A, 10'h3FF});
      do_req({TAG_A, 10'h155});
      expect_slot("R1", slot_of(TAG_A), 1'b1, TAG_A, 4);
      do_req(ADDR_A);
      expect_slot("R4", slot_of(TAG_A), 1'b1, TAG_A, 5);
      // R2: tag bits 21:18 fold onto index low bits
      do_req({22'h3C0000, 10'h0});
      expect_slot("R2", 9'h00F, 1'b1, 22'h3C0000, 1);
   endtask

   task automatic t_collision;
      chk("R2", "same slot", slot_of(TAG_B), slot_of(TAG_A));
      do_req({TAG_B, 10'h0});
      expect_slot("R3", slot_of(TAG_A), 1'b1, TAG_B, 1);
      do_req(ADDR_A);
      expect_slot("R3", slot_of(TAG_A), 1'b1, TAG_A, 1);
   endtask

   task automatic t_back_to_back;
      @(negedge clk); req_valid = 1'b1; req_addr = {22'd100, 10'h0};
      @(negedge clk); req_addr = {22'd200, 10'h0};
      @(negedge clk); req_addr = {22'd300, 10'h0};
      @(negedge clk); req_addr = {22'd100, 10'h8};
      @(negedge clk); req_valid = 1'b0;
      expect_slot("R6", 9'd100, 1'b1, 22'd100, 2);
      expect_slot("R6", 9'd200, 1'b1, 22'd200, 1);
      expect_slot("R6", 9'd300, 1'b1, 22'd300, 1);
   endtask

   task automatic t_read_latency;
      read_slot(9'd5);
      chk("R9", "empty slot", rd_valid, 0);
      @(negedge clk);
      rd_idx = 9'd200;
      #1;
      chk("R9", "before edge", rd_valid, 0);
      @(negedge clk);
      chk("R9", "after edge", rd_valid, 1);
      chk("R9", "after edge count", rd_count, 1);
   endtask

   task automatic t_saturate;
      @(negedge clk); req_valid = 1'b1; req_addr = {22'd77, 10'h0};
      for (int i = 0; i < 65534; i++) @(negedge clk);
      req_valid = 1'b0;
      expect_slot("R5", 9'd77, 1'b1, 22'd77, 65534);
      @(negedge clk); req_valid = 1'b1;
      for (int i = 0; i < 6; i++) @(negedge clk);
      req_valid = 1'b0;
      expect_slot("R5", 9'd77, 1'b1, 22'd77, 65535);
   endtask

   task automatic t_clear;
      int busy_cycles = 0;
      @(negedge clk);
      epoch_clear = 1'b1; req_valid = 1'b1; req_addr = {22'd400, 10'h0};
      @(negedge clk);
      epoch_clear = 1'b0; req_addr = {22'd401, 10'h0};
      chk("R7", "busy after pulse", clear_busy, 1);
      for (int i = 0; i < 700; i++) begin
         if (clear_busy) busy_cycles++;
         if (i == 100) epoch_clear = 1'b1;
         if (i == 101) epoch_clear = 1'b0;
         if (i == 300) req_valid = 1'b0;
         @(negedge clk);
      end
      chk("R11", "busy cycles with mid pulse", busy_cycles, 512);
      expect_slot("R7", slot_of(TAG_A), 1'b0, '0, 0);
      expect_slot("R7", 9'd77, 1'b0, '0, 0);
      expect_slot("R7", 9'd100, 1'b0, '0, 0);
      expect_slot("R8", 9'd400, 1'b0, '0, 0);
      expect_slot("R8", 9'd401, 1'b0, '0, 0);
      do_req({22'd401, 10'h0});
      expect_slot("R7", 9'd401, 1'b1, 22'd401, 1);
   endtask

   initial begin
      #(150000 * 5);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_and_repeat();
      t_collision();
      t_back_to_back();
      t_read_latency();
      t_saturate();
      t_clear();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule